// File: doc/BRIEF.md
# Replay FIFO with Mark and Rewind

This block is a single-clock first-in first-out buffer for 9-bit words whose depth is a parameter. Words come out in the order they went in. A writer pulses an active-low write strobe with a word on `din`. A reader pulses an active-low read strobe, and the word appears on `dout` one cycle later, qualified by `dout_vld`.

A consumer that may need to resend a stretch of data pulses `mark` to record the current read position. Later it drives `rt_n` low to rewind the read position to that record, and the words from the marked one onward come out again. While a mark is held, the writer cannot overwrite the marked word or anything after it.

Three active-low status lines report occupancy in six regions: empty, almost empty, below half, above half, almost full and full. The almost-regions come from an offset register that can be reloaded only while the buffer is empty.

Top module: `replay_fifo`

## Requirements
- R1: While `rst_n` is low at a rising edge, all pointers and the occupancy go to zero and the mark becomes invalid. `dout_vld` goes low and the offset register loads DEPTH/8.
- R2: Words are read out in the order they were accepted. The word for a read accepted at edge k is on `dout` after edge k.
- R3: A write while occupancy equals DEPTH is ignored. A read while occupancy is zero is ignored.
- R4: `dout_vld` is high after edge k exactly when a read was accepted at edge k, and it is therefore low whenever `rd_n` was high.
- R5: `mark` high at an edge copies the read position into the mark register and makes the mark valid. `rt_n` low while the mark is valid sets the read position to the mark. That retransmit takes priority over a read and a mark in the same cycle, and `rt_n` has no effect while no mark is valid.
- R6: `ef_n` is low when the occupancy is 0 or DEPTH, and high otherwise.
- R7: `hf_n` is low when the occupancy is greater than DEPTH/2. Together with `ef_n`, this tells Empty from Full.
- R8: `pafe_n` is low when the occupancy is at most the offset or at least DEPTH minus the offset.
- R9: `ofs_ld` high at an edge loads `ofs_in` into the offset register only if the occupancy is zero. Otherwise the load is ignored.
- R10: While a mark is valid, a write is refused when the write position is DEPTH words ahead of the mark.
- R11: After a retransmit, the occupancy equals the write position minus the mark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low master reset |
| wr_n | input | 1 | Active-low write strobe |
| din | input | 9 | Word to write |
| rd_n | input | 1 | Active-low read strobe |
| dout | output | 9 | Word read, one cycle after the strobe |
| dout_vld | output | 1 | High when `dout` carries a freshly read word |
| mark | input | 1 | Record the current read position |
| rt_n | input | 1 | Active-low rewind to the recorded position |
| ofs_ld | input | 1 | Load the almost-threshold offset |
| ofs_in | input | log2(DEPTH) | New offset value |
| ef_n | output | 1 | Low when empty or full |
| hf_n | output | 1 | Low when above half full |
| pafe_n | output | 1 | Low when within the offset of empty or of full |

## Verification
A corrupted read or mark position shows up on `dout` as a wrong or repeated word, one cycle after the next accepted read. A wrong occupancy shows up on the three status lines in the same cycle, because they decode the registered pointers with no further delay. A lost mark-valid bit shows up either as a rewind that does nothing or as a write that should have been refused. Both become visible through the status lines after the next edge.

// File: rtl/replay_fifo_pkg.sv
// Shared definitions for the replay FIFO.
// Assumes nothing beyond a 9-bit data word.
package replay_fifo_pkg;
    localparam int RF_DATA_W = 9;

    // Active-low status lines grouped together.
    typedef struct packed {
        logic ef_n;
        logic hf_n;
        logic pafe_n;
    } rf_flags_t;
endpackage

// File: rtl/rf_ptr_ctl.sv
// Pointer control: write, read and mark positions with a wrap bit.
// Accepts or refuses the strobes and derives occupancy and the span held by the mark.
// Assumes DEPTH is a power of two, so that the pointers wrap naturally.
module rf_ptr_ctl #(
    parameter int DEPTH = 256,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_n,
    input  logic          rd_n,
    input  logic          mark,
    input  logic          rt_n,
    output logic          wr_go,
    output logic          rd_go,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] rd_addr,
    output logic [PW-1:0] occ,
    output logic [PW-1:0] span,
    output logic [PW-1:0] wp_q,
    output logic [PW-1:0] rp_q,
    output logic [PW-1:0] mk_q,
    output logic          mark_vld
);
    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

    logic rt_go;
    logic mark_go;
    logic full;
    logic guard;

    // Decide which strobes take effect this cycle.
    always_comb begin
        occ     = wp_q - rp_q;
        span    = wp_q - mk_q;
        full    = (occ == DEPTH_P);
        guard   = mark_vld && (span == DEPTH_P);
        rt_go   = !rt_n && mark_vld;
        rd_go   = !rd_n && !rt_go && (occ != '0);
        wr_go   = !wr_n && !full && !guard;
        mark_go = mark && !rt_go;
        wr_addr = wp_q[AW-1:0];
        rd_addr = rp_q[AW-1:0];
    end

    // Advance the pointers and record the mark.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q     <= '0;
            rp_q     <= '0;
            mk_q     <= '0;
            mark_vld <= 1'b0;
        end else begin
            if (wr_go) wp_q <= wp_q + 1'b1;
            if (rt_go)      rp_q <= mk_q;
            else if (rd_go) rp_q <= rp_q + 1'b1;
            if (mark_go) begin
                mk_q     <= rp_q;
                mark_vld <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/rf_store.sv
// Word storage with a registered read port and a read-valid flag.
// Assumes the controller never writes and reads the same live slot in one cycle.
module rf_store #(
    parameter int DATA_W = 9,
    parameter int DEPTH  = 256,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_go,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] din,
    input  logic              rd_go,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] dout,
    output logic              dout_vld
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Store an accepted word.
    always_ff @(posedge clk) begin
        if (wr_go) mem[wr_addr] <= din;
    end

    // Present an accepted read and flag it valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout     <= '0;
            dout_vld <= 1'b0;
        end else begin
            dout_vld <= rd_go;
            if (rd_go) dout <= mem[rd_addr];
        end
    end
endmodule

// File: rtl/rf_flags.sv
// Offset register and status decode for the six fill regions.
// Assumes occ never exceeds DEPTH.
module rf_flags
    import replay_fifo_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] occ,
    input  logic          ofs_ld,
    input  logic [AW-1:0] ofs_in,
    output logic [AW-1:0] ofs_q,
    output rf_flags_t     flags
);
    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
    localparam logic [PW-1:0] HALF_P  = PW'(DEPTH / 2);
    localparam logic [AW-1:0] OFS_RST = AW'(DEPTH / 8);

    logic [PW-1:0] ofs_w;

    // Reload the offset only while the buffer is empty.
    always_ff @(posedge clk) begin
        if (!rst_n)                      ofs_q <= OFS_RST;
        else if (ofs_ld && occ == '0)    ofs_q <= ofs_in;
    end

    // Decode occupancy into the three active-low lines.
    always_comb begin
        ofs_w        = {1'b0, ofs_q};
        flags.ef_n   = !((occ == '0) || (occ == DEPTH_P));
        flags.hf_n   = !(occ > HALF_P);
        flags.pafe_n = !((occ <= ofs_w) || (occ >= DEPTH_P - ofs_w));
    end
endmodule

// File: rtl/replay_fifo.sv
// Top of the replay FIFO: pointer control, storage and status decode.
// Assumes one clock for both sides and a power-of-two DEPTH of at least 8.
module replay_fifo
    import replay_fifo_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_n,
    input  logic [RF_DATA_W-1:0] din,
    input  logic                 rd_n,
    output logic [RF_DATA_W-1:0] dout,
    output logic                 dout_vld,
    input  logic                 mark,
    input  logic                 rt_n,
    input  logic                 ofs_ld,
    input  logic [AW-1:0]        ofs_in,
    output logic                 ef_n,
    output logic                 hf_n,
    output logic                 pafe_n
);
    logic          wr_go;
    logic          rd_go;
    logic [AW-1:0] wr_addr;
    logic [AW-1:0] rd_addr;
    logic [PW-1:0] occ;
    logic [PW-1:0] span;
    logic [PW-1:0] wp_q;
    logic [PW-1:0] rp_q;
    logic [PW-1:0] mk_q;
    logic          mark_vld;
    logic [AW-1:0] ofs_q;
    rf_flags_t     flags;

    rf_ptr_ctl #(.DEPTH(DEPTH)) u_ptr (
        .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n),
        .mark(mark), .rt_n(rt_n), .wr_go(wr_go), .rd_go(rd_go),
        .wr_addr(wr_addr), .rd_addr(rd_addr), .occ(occ), .span(span),
        .wp_q(wp_q), .rp_q(rp_q), .mk_q(mk_q), .mark_vld(mark_vld)
    );

    rf_store #(.DATA_W(RF_DATA_W), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_go(wr_go), .wr_addr(wr_addr),
        .din(din), .rd_go(rd_go), .rd_addr(rd_addr),
        .dout(dout), .dout_vld(dout_vld)
    );

    rf_flags #(.DEPTH(DEPTH)) u_flags (
        .clk(clk), .rst_n(rst_n), .occ(occ), .ofs_ld(ofs_ld),
        .ofs_in(ofs_in), .ofs_q(ofs_q), .flags(flags)
    );

    // Bring the status struct out to the pins.
    always_comb begin
        ef_n   = flags.ef_n;
        hf_n   = flags.hf_n;
        pafe_n = flags.pafe_n;
    end
endmodule

// File: rtl/replay_fifo_chk.sv
// Temporal checks on the replay FIFO, attached to the top through bind.
// Assumes the internal names of replay_fifo.
module replay_fifo_chk #(
    parameter int DEPTH = 256,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rd_n,
    input logic          rt_n,
    input logic          dout_vld,
    input logic [PW-1:0] occ,
    input logic [PW-1:0] span,
    input logic [PW-1:0] wp_q,
    input logic [PW-1:0] rp_q,
    input logic [PW-1:0] mk_q,
    input logic          mark_vld,
    input logic [AW-1:0] ofs_q
);
    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= DEPTH_P);

    a_r3_empty_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == '0) |=> !dout_vld);

    a_r4_vld_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        dout_vld |-> $past(!rd_n));

    a_r5_rewind_to_mark: assert property (@(posedge clk) disable iff (!rst_n)
        (!rt_n && mark_vld) |=> (rp_q == $past(mk_q)));

    a_r9_offset_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (occ != '0) |=> $stable(ofs_q));

    a_r10_mark_guard: assert property (@(posedge clk) disable iff (!rst_n)
        (mark_vld && span == DEPTH_P) |=> $stable(wp_q));
endmodule

bind replay_fifo replay_fifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .rt_n(rt_n),
    .dout_vld(dout_vld), .occ(occ), .span(span), .wp_q(wp_q),
    .rp_q(rp_q), .mk_q(mk_q), .mark_vld(mark_vld), .ofs_q(ofs_q)
);

// File: tb/replay_fifo_tb.sv
// Bench: a 16-deep FIFO driven through directed sweeps and a long
// pseudo-random run. An arithmetic model is compared after every edge.
module replay_fifo_tb;
    localparam int D  = 16;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_n = 1'b1;
    logic [8:0]    din = '0;
    logic          rd_n = 1'b1;
    logic [8:0]    dout;
    logic          dout_vld;
    logic          mark = 1'b0;
    logic          rt_n = 1'b1;
    logic          ofs_ld = 1'b0;
    logic [AW-1:0] ofs_in = '0;
    logic          ef_n, hf_n, pafe_n;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    int m_wp, m_rp, m_mk, m_ofs, e_dout;
    bit m_mv, e_vld;
    int m_mem [D];
    int seed = 12345;

    always #2 clk = ~clk;

    replay_fifo #(.DEPTH(D)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .din(din), .rd_n(rd_n),
        .dout(dout), .dout_vld(dout_vld), .mark(mark), .rt_n(rt_n),
        .ofs_ld(ofs_ld), .ofs_in(ofs_in), .ef_n(ef_n), .hf_n(hf_n),
        .pafe_n(pafe_n)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Compare every output against the model (R2 R4 R6 R7 R8).
    task automatic chk_all();
        int c;
        c = m_wp - m_rp;
        chk(ef_n == !(c == 0 || c == D), "R6", "ef_n", ef_n, !(c == 0 || c == D));
        chk(hf_n == !(c > D/2), "R7", "hf_n", hf_n, !(c > D/2));
        chk(pafe_n == !(c <= m_ofs || c >= D - m_ofs), "R8", "pafe_n",
            pafe_n, !(c <= m_ofs || c >= D - m_ofs));
        chk(dout_vld == e_vld, "R4", "dout_vld", dout_vld, e_vld);
        if (e_vld) chk(dout == 9'(e_dout), "R2", "dout", dout, e_dout);
    endtask

    // One clock cycle: drive the inputs, advance the model, sample at the falling edge.
    task automatic cyc(input bit rst, input bit w, input int d, input bit r,
                       input bit m, input bit t, input bit l, input int o);
        int c;
        bit rt_go, rd_go, wr_go, mk_go, ld_go;
        rst_n = !rst; wr_n = !w; din = 9'(d); rd_n = !r;
        mark = m; rt_n = !t; ofs_ld = l; ofs_in = AW'(o);
        if (rst) begin
            m_wp = 0; m_rp = 0; m_mk = 0; m_mv = 0; m_ofs = D/8; e_vld = 0;
        end else begin
            c     = m_wp - m_rp;
            rt_go = t && m_mv;
            rd_go = r && !rt_go && c > 0;
            wr_go = w && c < D && !(m_mv && m_wp - m_mk >= D);
            mk_go = m && !rt_go;
            ld_go = l && c == 0;
            e_vld = rd_go;
            if (rd_go) e_dout = m_mem[m_rp % D];
            if (wr_go) begin m_mem[m_wp % D] = d; m_wp++; end
            if (ld_go) m_ofs = o;
            if (rt_go) m_rp = m_mk;
            else if (rd_go) m_rp++;
            if (mk_go) begin m_mk = (rt_go ? m_mk : m_rp - (rd_go ? 1 : 0)); m_mv = 1; end
        end
        @(posedge clk);
        @(negedge clk);
        chk_all();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int v;
        @(negedge clk);
        // R1: reset state
        cyc(1, 0, 0, 0, 0, 0, 0, 0);
        cyc(1, 0, 0, 0, 0, 0, 0, 0);
        chk(ef_n == 0 && hf_n == 1 && pafe_n == 0, "R1", "empty flags", {ef_n, hf_n, pafe_n}, 3'b010);
        // R3 R6 R7 R8: fill past full, sweeping every occupancy
        for (int i = 0; i < D + 2; i++) cyc(0, 1, 100 + i, 0, 0, 0, 0, 0);
        chk(ef_n == 0 && hf_n == 0, "R3", "full after overfill", {ef_n, hf_n}, 2'b00);
        // R2 R3 R4: drain past empty
        for (int i = 0; i < D + 2; i++) cyc(0, 0, 0, 1, 0, 0, 0, 0);
        chk(dout_vld == 0, "R3", "read on empty refused", dout_vld, 0);
        // R9: offset load while empty takes effect
        cyc(0, 0, 0, 0, 0, 0, 1, 5);
        for (int i = 0; i < D; i++) cyc(0, 1, 200 + i, 0, 0, 0, 0, 0);
        // R9: offset load while not empty is ignored
        cyc(0, 0, 0, 0, 0, 0, 1, 1);
        for (int i = 0; i < D; i++) cyc(0, 0, 0, 1, 0, 0, 0, 0);
        chk(pafe_n == 0 && m_ofs == 5, "R9", "offset kept", pafe_n, 0);
        // R5: rewind with no mark has no effect
        for (int i = 0; i < 6; i++) cyc(0, 1, 300 + i, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 1, 0, 1, 0, 0);
        chk(dout_vld == 1, "R5", "rewind without mark ignored", dout_vld, 1);
        // R5 R11: mark, read on, rewind, replay
        cyc(0, 0, 0, 1, 1, 0, 0, 0);
        cyc(0, 0, 0, 1, 0, 0, 0, 0);
        cyc(0, 0, 0, 1, 0, 0, 0, 0);
        cyc(0, 0, 0, 1, 0, 1, 0, 0);
        chk(dout_vld == 0, "R5", "rewind beats read", dout_vld, 0);
        chk(ef_n == 1 && hf_n == 1, "R11", "occupancy after rewind", {ef_n, hf_n}, 2'b11);
        cyc(0, 0, 0, 1, 0, 0, 0, 0);
        chk(dout == 9'd301, "R5", "replay from marked word", dout, 301);
        // R10: mark held, writer blocked once the span reaches DEPTH
        for (int i = 0; i < 4; i++) cyc(0, 0, 0, 1, 0, 0, 0, 0);
        for (int i = 0; i < D; i++) cyc(0, 1, 400 + i, 0, 0, 0, 0, 0);
        chk(ef_n == 1, "R10", "writes refused at mark span", ef_n, 1);
        cyc(0, 0, 0, 0, 0, 1, 0, 0);
        chk(ef_n == 0 && hf_n == 0, "R11", "full after rewind", {ef_n, hf_n}, 2'b00);
        for (int i = 0; i < D + 1; i++) cyc(0, 0, 0, 1, 0, 0, 0, 0);
        // R1: reset clears the mark and the offset
        cyc(1, 0, 0, 0, 0, 0, 0, 0);
        chk(pafe_n == 0 && ef_n == 0, "R1", "reset after traffic", {ef_n, pafe_n}, 0);
        // Pseudo-random traffic covering R2..R11 together
        for (int i = 0; i < 6000; i++) begin
            seed = seed * 1103515245 + 12345;
            v = (seed >>> 8) & 32'hFFFF;
            cyc((v % 499) == 0, (v & 3) != 0, v & 511, ((v >> 2) & 3) != 0,
                ((v >> 4) & 15) == 0, ((v >> 8) & 15) == 0,
                ((v >> 12) & 7) == 0, (v >> 3) & 7);
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule